// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Unit

This block fetches a cache line that missed from a word-serial memory and sends the words into the line storage. It is controlled by a mode input. In critical-word-first mode, it asks memory for a burst that starts at the word that missed and wraps around the line. In early-restart mode, the burst starts at word 0 and runs upward. In both modes, the missed word goes to the processor in the same cycle it arrives from memory. The rest of the line keeps filling behind it.

The unit accepts one miss at a time. Each miss produces a single-cycle burst request that carries the first word's address. Memory then returns one word per valid beat, in burst order, and may leave gaps between beats. For every beat, the unit drives a one-hot write enable, the word index and the write data for the line array. While the refill runs, the processor may probe a word of the line. The probe is allowed if that word has already been written and stalls if it has not. After the eighth beat, a completion flag rises and the unit becomes ready for the next miss.

Top module: `refill_unit`

## Requirements
- R1: After reset the unit is idle. missReady is 1 and lineDone is 0. memReqValid, lineWe and cpuValid are all 0.
- R2: A miss is taken on a clock edge where missValid and missReady are both 1. In the following cycle memReqValid is 1 for exactly one cycle. memReqAddr is the miss address with its low log2(WORDS*4) bits cleared, plus 4 times the first word's index (address bits [4:2] select the word for 8 words of 32 bits).
- R3: With modeCwf=1, the first word requested and written is the missed word. Beat k writes word (missed+k) mod WORDS.
- R4: With modeCwf=0, the request starts at word 0. Beat k writes word k.
- R5: cpuValid is 1 in the cycle of the beat that carries the missed word, with cpuData equal to that beat's memRdData. It is 1 exactly once per refill.
- R6: During a refill, each cycle with memRdValid=1 is one beat. In that cycle lineWe is one-hot, with the set bit equal to lineWordIdx, and lineWrData equals memRdData. In cycles without a beat, lineWe is 0.
- R7: lineDone rises in the cycle after the WORDS-th beat, together with missReady. It stays 1 until the next miss is taken. It never rises before all words are written.
- R8: missValid is ignored while missReady is 0. No new request is issued and the refill in progress is unchanged.
- R9: memRdValid is ignored while idle and during the request cycle. lineWe stays 0 and cpuValid stays 0.
- R10: From the request cycle until completion, cpuStall equals cpuRdValid AND the word cpuRdWord has not yet been written in an earlier cycle. While idle, cpuStall is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | A miss is presented |
| missAddr | input | ADDR_W | Byte address of the missed word |
| modeCwf | input | 1 | 1 = critical-word-first wrap order, 0 = ascending from word 0 |
| missReady | output | 1 | Unit can take a miss |
| memReqValid | output | 1 | One-cycle burst request to memory |
| memReqAddr | output | ADDR_W | Byte address of the first word of the burst |
| memRdValid | input | 1 | Memory data beat valid |
| memRdData | input | DATA_W | Memory data beat |
| lineWe | output | WORDS | One-hot word write enable for the line |
| lineWordIdx | output | log2(WORDS) | Word index being written |
| lineWrData | output | DATA_W | Data written into the line |
| cpuValid | output | 1 | Missed word delivered to the processor |
| cpuData | output | DATA_W | Missed word data |
| cpuRdValid | input | 1 | Processor probes a word of the refilling line |
| cpuRdWord | input | log2(WORDS) | Word index of the probe |
| cpuStall | output | 1 | Probed word not yet present |
| lineDone | output | 1 | Whole line written |

## Verification
Three kinds of results appear in the same cycle as their stimulus: the line write outputs, cpuValid/cpuData for a beat, and cpuStall for a probe. Three others appear one edge later: memReqValid after the miss is taken, lineDone and missReady after the last beat, and a written word that stops stalling. The bench drives inputs just after each rising edge and compares all outputs at the falling edge. There they are checked against a behavioural model whose state moves only at the rising edge, so each same-cycle and next-cycle result is checked in exactly the cycle it is due. The scenarios cover both modes, every missed-word position, gaps between beats, stray beats while idle and misses presented while busy.

// File: rtl/refill_pkg.sv
package refill_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadMiss;   // capture miss address and mode, clear progress
    logic issueReq;   // request cycle
    logic takeBeat;   // accept one memory beat into the line
    logic fillActive; // refill in progress (request or fill phase)
  } refill_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_FILL = 2'd2
  } refill_state_t;

endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           missValid,
  input  logic           memRdValid,
  input  logic           lastBeat,
  output refill_strobe_t strobes,
  output logic           missReady,
  output logic           memReqValid,
  output logic           lineDone
);

  refill_state_t stateQ, stateD;
  logic          doneQ;

  always_comb begin
    strobes            = '0;
    strobes.loadMiss   = (stateQ == ST_IDLE) && missValid;
    strobes.issueReq   = (stateQ == ST_REQ);
    strobes.takeBeat   = (stateQ == ST_FILL) && memRdValid;
    strobes.fillActive = (stateQ != ST_IDLE);
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (missValid) stateD = ST_REQ;
      ST_REQ:  stateD = ST_FILL;
      ST_FILL: if (memRdValid && lastBeat) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (strobes.loadMiss)
        doneQ <= 1'b0;
      else if (strobes.takeBeat && lastBeat)
        doneQ <= 1'b1;
    end
  end

  assign missReady   = (stateQ == ST_IDLE);
  assign memReqValid = strobes.issueReq;
  assign lineDone    = doneQ;

  // R2: the burst request lasts a single cycle
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R7: completion only follows the final beat
  p_done_last_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineDone) |-> $past(strobes.takeBeat && lastBeat));

  // R7: a completed line leaves the unit ready
  p_done_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> missReady);

  // R8: while busy the request line stays quiet
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!missReady && !memReqValid) |=> !memReqValid);

endmodule

// File: rtl/refill_datapath.sv
module refill_datapath
  import refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  refill_strobe_t    strobes,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              modeCwf,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              cpuRdValid,
  input  logic [IDX_W-1:0]  cpuRdWord,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [WORDS-1:0]  lineWe,
  output logic [IDX_W-1:0]  lineWordIdx,
  output logic [DATA_W-1:0] lineWrData,
  output logic              cpuValid,
  output logic [DATA_W-1:0] cpuData,
  output logic              cpuStall
);

  localparam int BYTE_OFF_W = $clog2(DATA_W / 8);
  localparam int LINE_OFF_W = IDX_W + BYTE_OFF_W;
  localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_OFF_W) - ADDR_W'(1));

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W-1:0]  critQ;
  logic              cwfQ;
  logic [IDX_W-1:0]  beatQ;
  logic [WORDS-1:0]  arrivedQ;
  logic              cpuSentQ;
  logic [IDX_W-1:0]  startIdx;
  logic [IDX_W-1:0]  curIdx;

  // Burst start: missed word for wrap order, word 0 for ascending order
  assign startIdx = cwfQ ? critQ : '0;
  // Width truncation gives the modulo-WORDS wrap
  assign curIdx   = startIdx + beatQ;
  assign lastBeat = (beatQ == IDX_W'(WORDS - 1));

  assign memReqAddr = baseQ | (ADDR_W'(startIdx) << BYTE_OFF_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ    <= '0;
      critQ    <= '0;
      cwfQ     <= 1'b0;
      beatQ    <= '0;
      arrivedQ <= '0;
      cpuSentQ <= 1'b0;
    end else if (strobes.loadMiss) begin
      baseQ    <= missAddr & LINE_MASK;
      critQ    <= missAddr[LINE_OFF_W-1:BYTE_OFF_W];
      cwfQ     <= modeCwf;
      beatQ    <= '0;
      arrivedQ <= '0;
      cpuSentQ <= 1'b0;
    end else if (strobes.takeBeat) begin
      beatQ            <= beatQ + 1'b1;
      arrivedQ[curIdx] <= 1'b1;
      if (cpuValid) cpuSentQ <= 1'b1;
    end
  end

  // One-hot write enable decode
  for (genvar w = 0; w < WORDS; w++) begin : g_we
    assign lineWe[w] = strobes.takeBeat && (curIdx == IDX_W'(w));
  end

  assign lineWordIdx = curIdx;
  assign lineWrData  = memRdData;

  // Early restart: the missed word passes straight through on its beat
  assign cpuValid = strobes.takeBeat && (curIdx == critQ);
  assign cpuData  = memRdData;

  assign cpuStall = cpuRdValid && strobes.fillActive && !arrivedQ[cpuRdWord];

  // R6: at most one word written per cycle
  p_we_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lineWe));

  // R5: the processor hears of the missed word only once per refill
  p_cpu_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> !cpuSentQ);

  // R3: in wrap order the first beat is the missed word
  p_cwf_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.takeBeat && beatQ == '0 && cwfQ) |-> cpuValid);

  // R10: a word delivered last cycle no longer stalls a probe
  p_served_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuValid) && cpuRdValid && cpuRdWord == critQ && strobes.fillActive) |-> !cpuStall);

endmodule

// File: rtl/refill_unit.sv
module refill_unit
  import refill_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              modeCwf,
  output logic              missReady,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic [WORDS-1:0]  lineWe,
  output logic [IDX_W-1:0]  lineWordIdx,
  output logic [DATA_W-1:0] lineWrData,
  output logic              cpuValid,
  output logic [DATA_W-1:0] cpuData,
  input  logic              cpuRdValid,
  input  logic [IDX_W-1:0]  cpuRdWord,
  output logic              cpuStall,
  output logic              lineDone
);

  refill_strobe_t strobes;
  logic           lastBeat;

  refill_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memRdValid  (memRdValid),
    .lastBeat    (lastBeat),
    .strobes     (strobes),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .lineDone    (lineDone)
  );

  refill_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WORDS  (WORDS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .missAddr    (missAddr),
    .modeCwf     (modeCwf),
    .memRdData   (memRdData),
    .cpuRdValid  (cpuRdValid),
    .cpuRdWord   (cpuRdWord),
    .lastBeat    (lastBeat),
    .memReqAddr  (memReqAddr),
    .lineWe      (lineWe),
    .lineWordIdx (lineWordIdx),
    .lineWrData  (lineWrData),
    .cpuValid    (cpuValid),
    .cpuData     (cpuData),
    .cpuStall    (cpuStall)
  );

endmodule

// File: tb/refill_unit_tb.sv
module refill_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        modeCwf = 1'b0;
  logic        missReady;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic [7:0]  lineWe;
  logic [2:0]  lineWordIdx;
  logic [31:0] lineWrData;
  logic        cpuValid;
  logic [31:0] cpuData;
  logic        cpuRdValid = 1'b0;
  logic [2:0]  cpuRdWord = '0;
  logic        cpuStall;
  logic        lineDone;

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;
  string scen = "reset";

  always #10 clk = ~clk; // 50 MHz

  refill_unit u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missAddr(missAddr),
    .modeCwf(modeCwf), .missReady(missReady), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .lineWe(lineWe), .lineWordIdx(lineWordIdx), .lineWrData(lineWrData),
    .cpuValid(cpuValid), .cpuData(cpuData), .cpuRdValid(cpuRdValid),
    .cpuRdWord(cpuRdWord), .cpuStall(cpuStall), .lineDone(lineDone)
  );

  // Behavioural reference model: phase 0 idle, 1 request, 2 filling
  int          mPhase = 0;
  int          mCount = 0;
  int          mCrit  = 0;
  bit          mCwf   = 0;
  bit          mDone  = 0;
  logic [31:0] mBase  = '0;
  bit          mHave[8];

  function automatic int mStart();
    return mCwf ? mCrit : 0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s [%s] actual=%h expected=%h at %0t", tag, what, scen, act, exp, $time);
    end
  endtask

  // Compare every output mid-cycle against the model
  always @(negedge clk) begin
    if (running) begin
      bit beat;
      int idx;
      beat = (mPhase == 2) && memRdValid;
      idx  = (mStart() + mCount) % 8;
      chk(mPhase == 0 && !mDone ? "R1" : "R7", 32'(missReady), 32'(mPhase == 0), "missReady");
      chk("R7", 32'(lineDone), 32'(mDone), "lineDone");
      chk("R2", 32'(memReqValid), 32'(mPhase == 1), "memReqValid");
      if (mPhase == 1)
        chk(mCwf ? "R3" : "R4", memReqAddr, mBase + 32'(mStart() * 4), "memReqAddr");
      chk(mPhase == 2 ? "R6" : "R9", 32'(lineWe), beat ? 32'(1 << idx) : 32'd0, "lineWe");
      if (beat) begin
        chk(mCwf ? "R3" : "R4", 32'(lineWordIdx), 32'(idx), "lineWordIdx");
        chk("R6", lineWrData, memRdData, "lineWrData");
      end
      chk("R5", 32'(cpuValid), 32'(beat && idx == mCrit), "cpuValid");
      if (beat && idx == mCrit)
        chk("R5", cpuData, memRdData, "cpuData");
      chk("R10", 32'(cpuStall), 32'(cpuRdValid && mPhase != 0 && !mHave[cpuRdWord]), "cpuStall");
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 0; mCount <= 0; mDone <= 0;
    end else begin
      case (mPhase)
        0: if (missValid) begin
             mBase  <= missAddr & 32'hFFFF_FFE0;
             mCrit  <= int'(missAddr[4:2]);
             mCwf   <= modeCwf;
             mCount <= 0;
             mDone  <= 0;
             foreach (mHave[i]) mHave[i] <= 1'b0;
             mPhase <= 1;
           end
        1: mPhase <= 2;
        default: if (memRdValid) begin
             mHave[(mStart() + mCount) % 8] <= 1'b1;
             if (mCount == 7) begin
               mPhase <= 0; mDone <= 1;
             end
             mCount <= mCount + 1;
           end
      endcase
    end
  end

  // Processor probes of the line, changing just after each edge
  always @(posedge clk) begin
    #2;
    cpuRdValid <= ($urandom % 3) != 0;
    cpuRdWord  <= 3'($urandom);
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // One refill: present the miss, wait for the request, return a burst
  task automatic refill(logic [31:0] addr, bit cwf, int gapEvery, bit missWhileBusy);
    logic [31:0] reqA;
    missValid = 1'b1; missAddr = addr; modeCwf = cwf;
    while (!missReady) step();
    step();
    missValid = missWhileBusy;       // R8: a second miss held while busy
    missAddr  = addr ^ 32'h0000_1F1C;
    modeCwf   = ~cwf;
    reqA = memReqAddr;
    // R9: a stray beat during the request cycle is ignored
    memRdValid = missWhileBusy; memRdData = 32'hDEAD_0000;
    step();
    for (int k = 0; k < 8; k++) begin
      if (gapEvery != 0 && (k % gapEvery) == 1) begin
        memRdValid = 1'b0;
        step();
      end
      memRdValid = 1'b1;
      memRdData  = {reqA[31:8], 8'(((int'(reqA[4:2]) + k) % 8) * 4)} ^ 32'h3C00_0000;
      step();
    end
    memRdValid = 1'b0;
    missValid  = 1'b0;
    step();
  endtask

  initial begin
    foreach (mHave[i]) mHave[i] = 1'b0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    running = 1'b1;
    scen = "R1 idle after reset";
    repeat (2) step();

    scen = "R9 beats while idle";
    memRdValid = 1'b1; memRdData = 32'hBAD0_BAD0;
    repeat (3) step();
    memRdValid = 1'b0;
    step();

    for (int w = 0; w < 8; w++) begin
      scen = "R3 wrap order";
      refill(32'h4000_1000 + 32'(w * 4) + 32'(w * 32'h100), 1'b1, 0, 1'b0);
    end
    for (int w = 0; w < 8; w++) begin
      scen = "R4 ascending order";
      refill(32'h8000_2000 + 32'(w * 4) + 32'(w * 32'h40), 1'b0, 3, 1'b0);
    end
    scen = "R8 miss while busy, wrap";
    refill(32'h1234_5678, 1'b1, 2, 1'b1);
    scen = "R8 miss while busy, ascending";
    refill(32'hCAFE_F00C, 1'b0, 2, 1'b1);
    scen = "R7 idle hold";
    repeat (4) step();

    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule